// File: doc/BRIEF.md
# Fast UART Host Register and Interrupt Unit

This block is the processor-facing half of a high-rate serial port. It has five word-wide registers on a simple strobe bus: a data window, a fill-level view, an interrupt cause register, a control word and a baud divisor. It holds two 64-deep byte queues. The transmit queue is loaded from the bus and drained by an external shift engine. The receive queue is loaded by that engine and drained by the bus. The engine talks to this unit through push and pop strobes. A received byte comes with a framing-error flag and a break flag, and a character-time strobe `char_tick` marks each idle character period on the line.

The unit latches interrupt causes and compares the fill counts against trigger levels that the control word selects. A small state machine measures receive inactivity. It has three states. `T_IDLE` means no data is waiting or the timeout is disabled. `T_COUNT` means character times are being counted. `T_EXPIRED` means the limit was reached. Four transitions connect them. IDLE to COUNT happens one cycle after data is present and a limit is selected. COUNT to COUNT, with the count cleared, happens on any push or pop. COUNT to EXPIRED happens when the tick count reaches the limit. EXPIRED to COUNT happens on a push or pop. Any state returns to IDLE when the queue empties or the limit is set to 0. A single interrupt line combines the enabled causes.

Top module: `hsu_host_regs`

## Requirements
- R1: A read of the data window (offset 0x00) returns the oldest received byte in bits 7:0, its framing flag in bit 9 and its break flag in bit 10, and removes that entry. When the receive queue is empty, the read returns 0x100 (bit 8 set) and removes nothing.
- R2: A write to the data window pushes `wdata[7:0]` into the transmit queue, up to 64 entries; writes to a full queue are dropped. `tx_byte` shows the oldest entry, `tx_avail` is high while the queue is not empty, and each `tx_pop` removes one entry.
- R3: A `rx_push` into a full receive queue (64 entries) is dropped and latches the overrun cause.
- R4: The level register (offset 0x04) reads the transmit count in bits 15:8 and the receive count in bits 7:0.
- R5: The cause register (offset 0x08) reads transmit request in bit 0, receive trigger in bit 1, receive timeout in bit 2, framing in bit 3, break in bit 4 and overrun in bit 5. Accepting a byte with `rx_ferr` set latches the framing cause, and accepting a byte with `rx_brk` set latches the break cause.
- R6: Writing 1 to cause bit 0, 3, 4 or 5 clears that latch, and writing 0 leaves it unchanged. Writing 1 to bit 6 sets the transmit request latch. Bit 6 reads as 0.
- R7: The control register (offset 0x0C) holds the transmit trigger code in bits 1:0, the receive trigger code in bits 4:2, the transmit enable in bit 5, the receive enable in bit 6, the error enable in bit 7, the break force in bit 8 and the timeout code in bits 17:16. It reads back only these bits. Bit 8 drives `tx_break`.
- R8: The receive trigger (cause bit 1) is high while the receive count is at or above the selected level. Codes 0 to 5 select 1, 4, 8, 16, 32 and 48 bytes, and codes 6 and 7 also select 48.
- R9: The transmit request latch sets when a `tx_pop` leaves the transmit count at or below the selected level. Codes 0 to 3 select 0, 4, 8 and 16 bytes.
- R10: Timeout code 0 disables the receive timeout. Codes 1 to 3 raise cause bit 2 after 4, 8 or 16 `char_tick` pulses in `T_COUNT`, following the transitions named above. Cause bit 2 is never set with an empty receive queue.
- R11: `irq` is high exactly when at least one of these holds: transmit request with the transmit enable set, receive trigger or timeout with the receive enable set, or framing, break or overrun with the error enable set.
- R12: The rate register (offset 0x10) stores `wdata[7:0]`, reads back in bits 7:0 and drives `rate_div`.
- R13: After reset both queues are empty, and control, rate and all causes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on data window) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Engine takes one transmit byte |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break seen with this byte |
| char_tick | input | 1 | One pulse per idle character time |
| tx_break | output | 1 | Force break on the line |
| rate_div | output | 8 | Baud divisor to the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every strobe is one clean cycle wide and that nothing is driven while reset is low. They also assume that `rx_push` and a clearing write to the cause register never meet in the same cycle when the overrun clear is being checked. The directed bench drives each strobe on a falling edge for exactly one cycle and never overlaps bus writes with engine pushes. It issues `char_tick` only as isolated pulses, so the tick count that the timeout properties rely on is unambiguous.

// File: rtl/hsu_pkg.sv
package hsu_pkg;

    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RATE  = 5'h10;

    typedef enum logic [1:0] {
        T_IDLE    = 2'd0,
        T_COUNT   = 2'd1,
        T_EXPIRED = 2'd2
    } tmo_state_e;

    // receive trigger level in bytes
    function automatic logic [7:0] rx_thresh(input logic [2:0] code);
        case (code)
            3'd0:    rx_thresh = 8'd1;
            3'd1:    rx_thresh = 8'd4;
            3'd2:    rx_thresh = 8'd8;
            3'd3:    rx_thresh = 8'd16;
            3'd4:    rx_thresh = 8'd32;
            default: rx_thresh = 8'd48;
        endcase
    endfunction

    // transmit trigger: bytes remaining
    function automatic logic [7:0] tx_thresh(input logic [1:0] code);
        case (code)
            2'd0:    tx_thresh = 8'd0;
            2'd1:    tx_thresh = 8'd4;
            2'd2:    tx_thresh = 8'd8;
            default: tx_thresh = 8'd16;
        endcase
    endfunction

    // inactivity limit in character times, 0 = off
    function automatic logic [4:0] tmo_chars(input logic [1:0] code);
        case (code)
            2'd0:    tmo_chars = 5'd0;
            2'd1:    tmo_chars = 5'd4;
            2'd2:    tmo_chars = 5'd8;
            default: tmo_chars = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/hsu_fifo.sv
module hsu_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hsu_rx_timer.sv
module hsu_rx_timer
    import hsu_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          has_data,
    input  logic          activity,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);

    tmo_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= T_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!has_data || limit == '0) begin
            st_d  = T_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                T_IDLE: begin
                    st_d  = T_COUNT;
                    cnt_d = '0;
                end
                T_COUNT: begin
                    if (activity) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q + CW'(1) == limit) begin
                            st_d  = T_EXPIRED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                T_EXPIRED: begin
                    if (activity) begin
                        st_d  = T_COUNT;
                        cnt_d = '0;
                    end
                end
                default: st_d = T_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        expired = (st_q == T_EXPIRED);
    end

endmodule

// File: rtl/hsu_host_regs.sv
module hsu_host_regs
    import hsu_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              char_tick,
    output logic              tx_break,
    output logic [7:0]        rate_div,
    output logic              irq
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned RXW   = 10;

    // control fields
    logic [1:0] tx_lvl_q, tmo_sel_q;
    logic [2:0] rx_lvl_q;
    logic       tx_ie_q, rx_ie_q, err_ie_q, brk_q;
    logic [7:0] rate_q;

    // latched causes
    logic txreq_q, fe_q, bk_q, ovr_q;

    // queue wiring
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [RXW-1:0]   rx_dout;
    logic             wr_data, wr_cause, wr_ctrl, wr_rate, rd_data;
    logic             rx_trig, rx_tmo, rx_take, rx_give;

    logic unused_hi;
    assign unused_hi = ^{wdata[31:18], wdata[2:1]};

    assign wr_data  = wr_en && (addr == OFS_DATA);
    assign wr_cause = wr_en && (addr == OFS_CAUSE);
    assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
    assign wr_rate  = wr_en && (addr == OFS_RATE);
    assign rd_data  = rd_en && (addr == OFS_DATA);

    hsu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_data),
        .din   (wdata[7:0]),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    hsu_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   ({rx_brk, rx_ferr, rx_byte}),
        .pop   (rd_data),
        .dout  (rx_dout),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_take = rx_push && !rx_full;
    assign rx_give = rd_data && !rx_empty;

    hsu_rx_timer #(.CW(5)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .has_data (!rx_empty),
        .activity (rx_take || rx_give),
        .tick     (char_tick),
        .limit    (tmo_chars(tmo_sel_q)),
        .expired  (rx_tmo)
    );

    assign rx_trig = (rx_cnt >= CNT_W'(rx_thresh(rx_lvl_q)));

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_lvl_q  <= '0;
            rx_lvl_q  <= '0;
            tx_ie_q   <= 1'b0;
            rx_ie_q   <= 1'b0;
            err_ie_q  <= 1'b0;
            brk_q     <= 1'b0;
            tmo_sel_q <= '0;
            rate_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_lvl_q  <= wdata[1:0];
                rx_lvl_q  <= wdata[4:2];
                tx_ie_q   <= wdata[5];
                rx_ie_q   <= wdata[6];
                err_ie_q  <= wdata[7];
                brk_q     <= wdata[8];
                tmo_sel_q <= wdata[17:16];
            end
            if (wr_rate) rate_q <= wdata[7:0];
        end
    end

    // cause latches: a set in the same cycle wins over a clear
    logic tx_fall;
    assign tx_fall = tx_pop && !tx_empty &&
                     ((tx_cnt - CNT_W'(1)) <= CNT_W'(tx_thresh(tx_lvl_q)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txreq_q <= 1'b0;
            fe_q    <= 1'b0;
            bk_q    <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            txreq_q <= tx_fall || (wr_cause && wdata[6]) ||
                       (txreq_q && !(wr_cause && wdata[0]));
            fe_q    <= (rx_take && rx_ferr) || (fe_q && !(wr_cause && wdata[3]));
            bk_q    <= (rx_take && rx_brk)  || (bk_q && !(wr_cause && wdata[4]));
            ovr_q   <= (rx_push && rx_full) || (ovr_q && !(wr_cause && wdata[5]));
        end
    end

    // read mux
    always_comb begin
        unique case (addr)
            OFS_DATA:  rdata = rx_empty ? 32'h0000_0100
                             : {21'd0, rx_dout[9], rx_dout[8], 1'b0, rx_dout[7:0]};
            OFS_LEVEL: rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
            OFS_CAUSE: rdata = {26'd0, ovr_q, bk_q, fe_q, rx_tmo, rx_trig, txreq_q};
            OFS_CTRL:  rdata = {14'd0, tmo_sel_q, 7'd0, brk_q, err_ie_q, rx_ie_q,
                                tx_ie_q, rx_lvl_q, tx_lvl_q};
            OFS_RATE:  rdata = {24'd0, rate_q};
            default:   rdata = 32'd0;
        endcase
    end

    assign tx_avail = !tx_empty;
    assign tx_break = brk_q;
    assign rate_div = rate_q;
    assign irq      = (tx_ie_q && txreq_q) ||
                      (rx_ie_q && (rx_trig || rx_tmo)) ||
                      (err_ie_q && (fe_q || bk_q || ovr_q));

    logic unused_full;
    assign unused_full = tx_full;

endmodule

// File: rtl/hsu_host_regs_chk.sv
module hsu_host_regs_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [4:0]       addr,
    input logic             wd_ovr,
    input logic             rx_push,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             ovr_q,
    input logic             rx_tmo,
    input logic             tx_ie,
    input logic             rx_ie,
    input logic             err_ie,
    input logic             irq
);

    assert_rx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH));

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH));

    assert_overrun_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == CNT_W'(DEPTH)) |=> ovr_q);

    assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h08 && wd_ovr && !rx_push) |=> !ovr_q);

    assert_data_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'h00 && rx_cnt != '0 && !rx_push)
        |=> rx_cnt == $past(rx_cnt) - CNT_W'(1));

    assert_tmo_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo |-> rx_cnt != '0);

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ie || rx_ie || err_ie) |-> !irq);

endmodule

bind hsu_host_regs hsu_host_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wd_ovr  (wdata[5]),
    .rx_push (rx_push),
    .rx_cnt  (rx_cnt),
    .tx_cnt  (tx_cnt),
    .ovr_q   (ovr_q),
    .rx_tmo  (rx_tmo),
    .tx_ie   (tx_ie_q),
    .rx_ie   (rx_ie_q),
    .err_ie  (err_ie_q),
    .irq     (irq)
);

// File: tb/hsu_host_regs_tb.sv
`timescale 1ns/1ps
module hsu_host_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  tx_byte, rx_byte = '0, rate_div;
    logic        tx_avail, tx_pop = 1'b0, rx_push = 1'b0;
    logic        rx_ferr = 1'b0, rx_brk = 1'b0, char_tick = 1'b0;
    logic        tx_break, irq;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    hsu_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .rx_ferr(rx_ferr),
        .rx_brk(rx_brk), .char_tick(char_tick), .tx_break(tx_break),
        .rate_div(rate_div), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b, input logic fe, input logic bk);
        @(negedge clk); rx_push = 1'b1; rx_byte = b; rx_ferr = fe; rx_brk = bk;
        @(negedge clk); rx_push = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic txp();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); char_tick = 1'b1;
            @(negedge clk); char_tick = 1'b0;
        end
    endtask

    task automatic drain_rx();
        logic [31:0] d;
        for (int i = 0; i < 70; i++) begin
            bus_rd(5'h00, d);
            if (d[8]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(5'h04, d); chk(d, 32'h0, "R13 level");
        bus_rd(5'h08, d); chk(d, 32'h0, "R13 cause");
        bus_rd(5'h0C, d); chk(d, 32'h0, "R13 ctrl");
        bus_rd(5'h10, d); chk(d, 32'h0, "R13 rate");
        chk({31'd0, irq}, 0, "R13 irq");
        bus_rd(5'h00, d); chk(d, 32'h100, "R1 empty read");
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_wr(5'h0C, 32'hFFFF_FFFF);
        bus_rd(5'h0C, d); chk(d, 32'h0003_01FF, "R7 ctrl readback");
        chk({31'd0, tx_break}, 1, "R7 break pin");
        bus_wr(5'h0C, 32'h0);
        chk({31'd0, tx_break}, 0, "R7 break off");
        bus_wr(5'h10, 32'h1A5);
        bus_rd(5'h10, d); chk(d, 32'hA5, "R12 rate read");
        chk({24'd0, rate_div}, 32'hA5, "R12 rate pin");
    endtask

    task automatic t_rx_data();
        logic [31:0] d;
        rx_in(8'h5A, 0, 0);
        rx_in(8'h33, 1, 0);
        rx_in(8'hC0, 0, 1);
        bus_rd(5'h04, d); chk(d, 32'h0003, "R4 rx level");
        bus_rd(5'h08, d); chk(d & 32'h18, 32'h18, "R5 fe and brk latched");
        bus_rd(5'h00, d); chk(d, 32'h05A, "R1 plain byte");
        bus_rd(5'h00, d); chk(d, 32'h233, "R1 framing byte");
        bus_rd(5'h00, d); chk(d, 32'h4C0, "R1 break byte");
        bus_rd(5'h00, d); chk(d, 32'h100, "R1 empty after drain");
        bus_wr(5'h08, 32'h0);
        bus_rd(5'h08, d); chk(d & 32'h18, 32'h18, "R6 zero write keeps");
        bus_wr(5'h08, 32'h08);
        bus_rd(5'h08, d); chk(d & 32'h18, 32'h10, "R6 fe cleared only");
        bus_wr(5'h08, 32'h10);
        bus_rd(5'h08, d); chk(d, 32'h0, "R6 brk cleared");
    endtask

    task automatic t_tx();
        logic [31:0] d;
        bus_wr(5'h00, 32'hA1); bus_wr(5'h00, 32'hB2);
        bus_rd(5'h04, d); chk(d, 32'h0200, "R4 tx level");
        chk({23'd0, tx_avail, tx_byte}, 32'h1A1, "R2 head byte");
        txp();
        chk({23'd0, tx_avail, tx_byte}, 32'h1B2, "R2 next byte");
        bus_rd(5'h08, d); chk(d[0], 0, "R9 no req at 1 left");
        txp();
        bus_rd(5'h08, d); chk(d[0], 1, "R9 req on empty");
        chk({31'd0, tx_avail}, 0, "R2 avail low");
        bus_wr(5'h08, 32'h01);
        bus_rd(5'h08, d); chk(d[0], 0, "R6 tx req cleared");
        bus_wr(5'h0C, 32'h1);
        for (int i = 0; i < 6; i++) bus_wr(5'h00, i);
        txp();
        bus_rd(5'h08, d); chk(d[0], 0, "R9 5 left no req");
        txp();
        bus_rd(5'h08, d); chk(d[0], 1, "R9 4 left req");
        bus_wr(5'h08, 32'h01);
        bus_wr(5'h08, 32'h40);
        bus_rd(5'h08, d); chk(d, 32'h1, "R6 bit6 sets req");
        bus_wr(5'h0C, 32'h21);
        chk({31'd0, irq}, 1, "R11 tx irq");
        bus_wr(5'h0C, 32'h1);
        bus_wr(5'h08, 32'h01);
        for (int i = 0; i < 4; i++) txp();
        bus_wr(5'h08, 32'h01);
        for (int i = 0; i < 70; i++) bus_wr(5'h00, 32'h40 + i);
        bus_rd(5'h04, d); chk(d, 32'h4000, "R2 tx capped at 64");
        chk({24'd0, tx_byte}, 32'h40, "R2 full head");
        for (int i = 0; i < 64; i++) txp();
        bus_wr(5'h08, 32'h01);
        bus_wr(5'h0C, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 0; i < 65; i++) rx_in(8'(i + 1), 0, 0);
        bus_rd(5'h04, d); chk(d, 32'h0040, "R3 rx capped at 64");
        bus_rd(5'h08, d); chk(d[5], 1, "R3 overrun latched");
        chk({31'd0, irq}, 0, "R11 no irq unenabled");
        bus_wr(5'h0C, 32'h80);
        chk({31'd0, irq}, 1, "R11 err irq");
        bus_wr(5'h08, 32'h20);
        bus_rd(5'h08, d); chk(d[5], 0, "R6 overrun cleared");
        chk({31'd0, irq}, 0, "R11 err irq gone");
        bus_wr(5'h0C, 32'h0);
        bus_rd(5'h00, d); chk(d, 32'h001, "R3 oldest kept");
        drain_rx();
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        bus_wr(5'h0C, 32'h08);
        for (int i = 0; i < 7; i++) rx_in(8'h10, 0, 0);
        bus_rd(5'h08, d); chk(d[1], 0, "R8 below 8");
        rx_in(8'h11, 0, 0);
        bus_rd(5'h08, d); chk(d[1], 1, "R8 at 8");
        chk({31'd0, irq}, 0, "R11 rx gated off");
        bus_wr(5'h0C, 32'h48);
        chk({31'd0, irq}, 1, "R11 rx irq");
        bus_wr(5'h0C, 32'h5C);
        bus_rd(5'h08, d); chk(d[1], 0, "R8 code7 is 48");
        chk({31'd0, irq}, 0, "R11 rx irq off");
        bus_wr(5'h0C, 32'h0);
        drain_rx();
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        bus_wr(5'h0C, 32'h0001_0054);
        rx_in(8'h77, 0, 0);
        tk(3);
        bus_rd(5'h08, d); chk(d[2], 0, "R10 3 ticks");
        tk(1);
        bus_rd(5'h08, d); chk(d[2], 1, "R10 4 ticks");
        chk({31'd0, irq}, 1, "R11 timeout irq");
        rx_in(8'h78, 0, 0);
        bus_rd(5'h08, d); chk(d[2], 0, "R10 push restarts");
        tk(4);
        bus_rd(5'h08, d); chk(d[2], 1, "R10 expired again");
        bus_rd(5'h00, d); chk(d, 32'h077, "R1 pop in timeout");
        bus_rd(5'h08, d); chk(d[2], 0, "R10 pop restarts");
        tk(4);
        bus_rd(5'h08, d); chk(d[2], 1, "R10 third expiry");
        bus_wr(5'h0C, 32'h54);
        tk(5);
        bus_rd(5'h08, d); chk(d[2], 0, "R10 code0 off");
        bus_wr(5'h0C, 32'h0002_0054);
        tk(7);
        bus_rd(5'h08, d); chk(d[2], 0, "R10 code2 7 ticks");
        tk(1);
        bus_rd(5'h08, d); chk(d[2], 1, "R10 code2 8 ticks");
        drain_rx();
        bus_rd(5'h08, d); chk(d[2], 0, "R10 empty idle");
        bus_wr(5'h0C, 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rx_data();
        t_tx();
        t_overrun();
        t_trigger();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule